// File: doc/BRIEF.md
# Binary-Weighted LED Brightness Sequencer

This block drives eight LED output pins with bit angle modulation, also called binary code modulation. Each channel holds an 8-bit brightness value. A frame is split into eight time slices, one for each bit position. The slice for bit n is held for 2^n ticks of an external periodic tick strobe. During that slice, each pin shows bit n of its channel's value, so a pin is high for as many ticks per frame as its brightness value.

The host writes one channel at a time, giving a channel index and an 8-bit value. The values are stored as transposed bit-planes: one word per bit position, and bit k of a plane belongs to channel k. A write updates bit k of all eight planes in a single clock cycle. The output word is loaded whole from one plane, and only when a new slice begins. Because of this, the pins never show a half-written set of planes.

A one-hot mask marks the current slice and rotates left at each slice change. A down-counter is reloaded from that mask, so no per-channel compare logic is needed.

Top module: `bam_led_driver`

## Requirements
- R1: After reset, all planes and the output word are zero. Slice 0 is current, and it ends after the first tick.
- R2: Slices run in the order 0,1,...,7 and then wrap to 0. Slice n lasts exactly 2^n ticks, so a frame lasts 255 ticks.
- R3: The output word changes only at a slice boundary, which is a tick that ends the current slice.
- R4: After a boundary into slice n, output bit k equals bit n of channel k's value as stored at that boundary.
- R5: A write with index k changes only channel k. The values of all other channels are kept.
- R6: A written value appears on the pins only from the next boundary. A write in the same cycle as a boundary is not seen at that boundary, and the output loaded there uses the old planes entirely.
- R7: Over one frame, a channel's pin is high for exactly as many ticks as its value. A value of 0 keeps the pin low for the whole frame. A value of 255 keeps it high for all 255 ticks.
- R8: In a cycle with tick_i low, the slice, the counter and the outputs do not change.
- R9: The slice mask is always one-hot. Its set bit always matches the slice index, and the counter stays between 1 and the mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe; one pulse is one tick |
| wr_en_i | input | 1 | Channel write strobe |
| wr_idx_i | input | 3 | Channel index to write |
| wr_val_i | input | 8 | Brightness value for the written channel |
| led_o | output | 8 | Modulated LED outputs, bit k is channel k |

## Verification
The checker watches the sequencer on every cycle:
- the mask stays one-hot and matches the slice index;
- the counter stays within range and is reloaded from the mask;
- the mask wraps after the top slice;
- nothing moves without a tick;
- the outputs stay frozen between boundaries.

Some behaviours can only be shown by the directed scenarios, because they depend on values the host wrote:
- whether the pins carry the right bit of each channel;
- per-channel duty counts over a frame;
- channel isolation;
- the deferral of a write to the next boundary, including the case where a write and a boundary fall in the same cycle.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int unsigned DEF_CH_N = 8;
  localparam int unsigned DEF_BITS = 8;

  typedef enum logic [0:0] {
    SEQ_HOLD = 1'b0,
    SEQ_ADV  = 1'b1
  } seq_step_e;
endpackage

// File: rtl/bam_plane_store.sv
module bam_plane_store #(
  parameter int unsigned CH_N  = bam_pkg::DEF_CH_N,
  parameter int unsigned BITS  = bam_pkg::DEF_BITS,
  localparam int unsigned IDX_W = $clog2(CH_N),
  localparam int unsigned POS_W = $clog2(BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [BITS-1:0]  wr_val_i,
  input  logic [POS_W-1:0] rd_pos_i,
  output logic [CH_N-1:0]  rd_plane_o
);
  // plane_q[n][k] = bit n of channel k
  logic [BITS-1:0][CH_N-1:0] plane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plane_q <= '0;
    end else if (wr_en_i) begin
      for (int p = 0; p < int'(BITS); p++) begin
        for (int c = 0; c < int'(CH_N); c++) begin
          if (wr_idx_i == IDX_W'(c)) plane_q[p][c] <= wr_val_i[p];
        end
      end
    end
  end

  // registered store read before update: a same-cycle write is invisible
  assign rd_plane_o = plane_q[rd_pos_i];
endmodule

// File: rtl/bam_sequencer.sv
module bam_sequencer #(
  parameter int unsigned BITS  = bam_pkg::DEF_BITS,
  localparam int unsigned POS_W = $clog2(BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             adv_o,
  output logic [POS_W-1:0] nxt_pos_o,
  output logic [POS_W-1:0] pos_o,
  output logic [BITS-1:0]  mask_o,
  output logic [BITS-1:0]  cnt_o
);
  import bam_pkg::*;

  localparam logic [BITS-1:0] MASK_FIRST = BITS'(1);

  logic [BITS-1:0]  mask_q, mask_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [BITS-1:0]  cnt_q, cnt_d;
  seq_step_e        step;

  // slice ends on the tick that takes the counter to zero
  assign step = (tick_i && cnt_q == BITS'(1)) ? SEQ_ADV : SEQ_HOLD;

  always_comb begin
    mask_d = mask_q;
    pos_d  = pos_q;
    cnt_d  = cnt_q;
    if (step == SEQ_ADV) begin
      if (mask_q[BITS-1]) begin
        mask_d = MASK_FIRST;
        pos_d  = '0;
      end else begin
        mask_d = mask_q << 1;
        pos_d  = pos_q + 1'b1;
      end
      cnt_d = mask_d;
    end else if (tick_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_FIRST;
      pos_q  <= '0;
      cnt_q  <= BITS'(1);
    end else begin
      mask_q <= mask_d;
      pos_q  <= pos_d;
      cnt_q  <= cnt_d;
    end
  end

  assign adv_o     = (step == SEQ_ADV);
  assign nxt_pos_o = pos_d;
  assign pos_o     = pos_q;
  assign mask_o    = mask_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/bam_out_reg.sv
module bam_out_reg #(
  parameter int unsigned CH_N = bam_pkg::DEF_CH_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CH_N-1:0] plane_i,
  output logic [CH_N-1:0] led_o
);
  logic [CH_N-1:0] led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     led_q <= '0;
    else if (load_i) led_q <= plane_i;
  end

  assign led_o = led_q;
endmodule

// File: rtl/bam_led_driver.sv
module bam_led_driver #(
  parameter int unsigned CH_N = bam_pkg::DEF_CH_N,
  parameter int unsigned BITS = bam_pkg::DEF_BITS,
  localparam int unsigned IDX_W = $clog2(CH_N),
  localparam int unsigned POS_W = $clog2(BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [BITS-1:0]  wr_val_i,
  output logic [CH_N-1:0]  led_o
);
  logic             adv;
  logic [POS_W-1:0] nxt_pos, pos;
  logic [BITS-1:0]  mask, cnt;
  logic [CH_N-1:0]  plane;

  bam_sequencer #(.BITS(BITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .adv_o     (adv),
    .nxt_pos_o (nxt_pos),
    .pos_o     (pos),
    .mask_o    (mask),
    .cnt_o     (cnt)
  );

  bam_plane_store #(.CH_N(CH_N), .BITS(BITS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_val_i   (wr_val_i),
    .rd_pos_i   (nxt_pos),
    .rd_plane_o (plane)
  );

  bam_out_reg #(.CH_N(CH_N)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (adv),
    .plane_i (plane),
    .led_o   (led_o)
  );
endmodule

// File: rtl/bam_led_driver_chk.sv
module bam_led_driver_chk #(
  parameter int unsigned CH_N = 8,
  parameter int unsigned BITS = 8,
  localparam int unsigned POS_W = $clog2(BITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             adv,
  input logic [POS_W-1:0] pos,
  input logic [BITS-1:0]  mask,
  input logic [BITS-1:0]  cnt,
  input logic [CH_N-1:0]  led_o
);
  assert_mask_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask) == 1);

  assert_pos_matches_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask == (BITS'(1) << pos));

  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != '0 && cnt <= mask);

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> cnt == mask);

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && mask[BITS-1] |=> pos == '0 && mask == BITS'(1));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !mask[BITS-1] |=> mask == ($past(mask) << 1));

  assert_out_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(led_o));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt) && $stable(mask) && $stable(pos));
endmodule

bind bam_led_driver bam_led_driver_chk #(.CH_N(CH_N), .BITS(BITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .adv    (adv),
  .pos    (pos),
  .mask   (mask),
  .cnt    (cnt),
  .led_o  (led_o)
);

// File: tb/tb_bam_led_driver.sv
module tb_bam_led_driver;
  localparam time CLK_PERIOD = 10ns;
  localparam int FRAME = 255;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_idx_i = '0;
  logic [7:0] wr_val_i = '0;
  logic [7:0] led_o;

  int checks = 0;
  int fails = 0;
  int ticks = 0;
  logic [7:0] chan [8];
  bit done = 1'b0;

  bam_led_driver dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slice_of(input int t);
    int r = t % FRAME;
    for (int p = 0; p < 8; p++) if (r < (2 << p) - 1) return p;
    return 7;
  endfunction

  function automatic logic [7:0] exp_led(input int p);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[k] = chan[k][p];
    return w;
  endfunction

  task automatic do_tick();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    ticks++;
  endtask

  task automatic write_ch(input int idx, input logic [7:0] val, input bit with_tick);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_val_i = val; tick_i = with_tick;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chan[idx] = val;
    if (with_tick) ticks++;
  endtask

  task automatic to_frame_start();
    do do_tick(); while (ticks % FRAME != 0);
  endtask

  // one full frame from a frame start: per-tick compare and duty count
  task automatic measure_frame(input string req);
    int bad = 0;
    int high [8];
    for (int k = 0; k < 8; k++) high[k] = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (led_o !== exp_led(slice_of(ticks))) bad++;
      for (int k = 0; k < 8; k++) if (led_o[k]) high[k]++;
      do_tick();
    end
    check({req, " per-tick pattern (R2 R4)"}, bad, 0);
    for (int k = 0; k < 8; k++) check({req, " duty count R7"}, high[k], chan[k]);
  endtask

  task automatic t_reset();
    check("R1 reset led", led_o, 8'h00);
    write_ch(0, 8'h02, 1'b0);
    check("R1 slice0 holds zero before first tick", led_o, 8'h00);
    do_tick();
    check("R1 slice1 after one tick", led_o[0], 1'b1);
    do_tick();
    check("R2 slice1 two ticks", led_o[0], 1'b1);
    do_tick();
    check("R2 slice2 begins", led_o[0], 1'b0);
  endtask

  task automatic t_pattern();
    logic [7:0] v [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'h7E};
    for (int k = 0; k < 8; k++) write_ch(k, v[k], 1'b0);
    to_frame_start();
    measure_frame("pattern");
  endtask

  task automatic t_isolation();
    write_ch(2, 8'h0F, 1'b0);
    to_frame_start();
    measure_frame("R5 isolation");
  endtask

  task automatic t_deferred();
    int bad = 0;
    write_ch(1, 8'hFF, 1'b0);
    to_frame_start();
    while (ticks % FRAME != 130) do_tick();
    check("R6 pre-write ch1 high", led_o[1], 1'b1);
    write_ch(1, 8'h00, 1'b0);
    while (ticks % FRAME != 0) begin
      if (led_o[1] !== 1'b1) bad++;
      do_tick();
    end
    check("R3 R6 no change until boundary", bad, 0);
    check("R6 new value at boundary", led_o[1], 1'b0);
  endtask

  task automatic t_coincident();
    write_ch(4, 8'h01, 1'b0);
    to_frame_start();
    while (ticks % FRAME != 254) do_tick();
    write_ch(4, 8'h00, 1'b1);
    check("R6 coincident write not seen at boundary", led_o[4], 1'b1);
    do_tick();
    check("R6 coincident write slice1", led_o[4], 1'b0);
    to_frame_start();
    check("R6 coincident write at next frame", led_o[4], 1'b0);
  endtask

  task automatic t_idle();
    logic [7:0] snap;
    int bad = 0;
    while (ticks % FRAME != 3) do_tick();
    snap = led_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (led_o !== snap) bad++;
    end
    check("R8 idle hold", bad, 0);
    do_tick(); // tick 4 still in slice2
    check("R8 slice timing kept", led_o, exp_led(2));
    do_tick(); // tick 5 still slice2
    do_tick(); // tick 6 still slice2
    do_tick(); // tick 7 -> slice3
    check("R2 slice3 after idle", led_o, exp_led(3));
    to_frame_start();
    measure_frame("R8 after idle");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) chan[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pattern();
    t_isolation();
    t_deferred();
    t_coincident();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule